// File: doc/BRIEF.md
# Multiplexed-Address DRAM Array Model

This block is a cycle-accurate synchronous model of a small dynamic memory device. It is meant to stand in for a memory inside a larger simulation or prototype. Storage is a square grid of supercells, and each supercell holds one data word. The default grid is 4 by 4 cells of 8 bits each. Row and column indices share one narrow address port. A row strobe copies the addressed row into an internal row buffer. Each later column strobe then reads or writes one supercell of that buffer. Any number of column accesses may reuse the open row.

A free-running timer models the need to refresh the cells periodically. When the interval expires, the block is busy for a fixed number of cycles. During that time it refreshes one row, stepping round-robin through the rows, and it accepts no request. A requester that sees busy simply holds its request until busy falls. Writes go both into the row buffer and into the backing grid. Opening another row therefore writes the buffer back and then loads the new row.

Top module: `dram_grid_model`

## Requirements
- R1: After reset every supercell reads as 0, no row is open, and `busy`, `rd_valid` and `col_err` are low.
- R2: A row strobe accepted while no row is open loads the row at `addr` into the row buffer and marks that row open.
- R3: A column read accepted while a row is open drives the buffered supercell at column `addr` on `rd_data`, with `rd_valid` high for exactly one cycle, one clock after acceptance.
- R4: After one row strobe, any number of column accesses are served from the same open row with no further row strobe.
- R5: A column write (`wr_en` high) stores `wr_data` in the open row's buffer and in the grid, and a later read of that cell returns it. `rd_valid` stays low for a write.
- R6: A column access accepted while no row is open raises `col_err` for one cycle, one clock later. `rd_valid` stays low and no cell changes.
- R7: A row strobe while a row is open writes the buffer back to its row, then opens the new row. Data written to any row survives switching away and back.
- R8: When row and column strobes are both high in the same accepted cycle, only the row strobe takes effect.
- R9: Counting from reset, every REFRESH_PERIOD cycles `busy` rises and stays high for exactly REFRESH_CYCLES cycles.
- R10: A strobe presented while `busy` is high has no effect. Once `busy` is low, a strobe held until then is served normally.
- R11: Each refresh advances the refreshed-row index by one, wrapping from the last row to row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| row_stb | input | 1 | Row strobe: `addr` carries a row index |
| col_stb | input | 1 | Column strobe: `addr` carries a column index |
| wr_en | input | 1 | With `col_stb`: 1 writes, 0 reads |
| addr | input | 2 | Shared row/column index |
| wr_data | input | 8 | Write word |
| rd_data | output | 8 | Read word, valid while `rd_valid` is high, held otherwise |
| rd_valid | output | 1 | One-cycle pulse marking read data |
| col_err | output | 1 | One-cycle pulse: column access with no open row |
| busy | output | 1 | Refresh in progress; strobes are not accepted |

## Verification
The assertions assume that REFRESH_CYCLES is smaller than REFRESH_PERIOD, so two refresh windows never overlap. They also assume the grid side is a power of two, so every address value names a real row or column. They place no limit on the strobes themselves: any mix of row, column, both or neither is legal in any cycle, including while busy. The stimulus therefore combines directed sequences with a long random stream that holds each request across busy windows, and it uses a short refresh period so that many refreshes fall in the middle of access sequences.

// File: rtl/dram_grid_pkg.sv
// Shared types for the multiplexed-address DRAM array model.
package dram_grid_pkg;
    // Operation taken in a cycle once strobes are qualified by busy.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_OPEN  = 2'd1,
        OP_READ  = 2'd2,
        OP_WRITE = 2'd3
    } dram_op_e;
endpackage

// File: rtl/dram_refresh_timer.sv
// Refresh timer: counts REFRESH_PERIOD cycles from reset, then holds busy
// for REFRESH_CYCLES cycles and advances the refreshed-row index.
// Assumes REFRESH_CYCLES < REFRESH_PERIOD and SIDE is a power of two.
module dram_refresh_timer #(
    parameter int REFRESH_PERIOD = 1024,
    parameter int REFRESH_CYCLES = 4,
    parameter int SIDE           = 4,
    localparam int CW            = $clog2(REFRESH_PERIOD),
    localparam int LW            = $clog2(REFRESH_CYCLES + 1),
    localparam int AW            = $clog2(SIDE)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          busy,
    output logic [AW-1:0] ref_row
);
    logic [CW-1:0] tick_cnt;
    logic [LW-1:0] left_cnt;
    logic          fire;

    assign fire = (tick_cnt == CW'(REFRESH_PERIOD - 1));

    // Interval counter that wraps every REFRESH_PERIOD cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    tick_cnt <= '0;
        else if (fire) tick_cnt <= '0;
        else           tick_cnt <= tick_cnt + 1'b1;
    end

    // Busy window and round-robin row pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            left_cnt <= '0;
            ref_row  <= '0;
        end else if (fire) begin
            busy     <= 1'b1;
            left_cnt <= LW'(REFRESH_CYCLES - 1);
            ref_row  <= (ref_row == AW'(SIDE - 1)) ? '0 : ref_row + 1'b1;
        end else if (busy) begin
            if (left_cnt == '0) busy <= 1'b0;
            else                left_cnt <= left_cnt - 1'b1;
        end
    end
endmodule

// File: rtl/dram_cell_array.sv
// Backing grid of SIDE x SIDE supercells of DW bits. Reads a whole row
// combinationally; writes either a whole row or one cell per cycle.
// Assumes the row and cell writes never target the same cycle.
module dram_cell_array #(
    parameter int SIDE = 4,
    parameter int DW   = 8,
    localparam int AW  = $clog2(SIDE),
    localparam int RW  = SIDE * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_row,
    output logic [RW-1:0] rd_vec,
    input  logic          wb_en,
    input  logic [AW-1:0] wb_row,
    input  logic [RW-1:0] wb_vec,
    input  logic          cw_en,
    input  logic [AW-1:0] cw_row,
    input  logic [AW-1:0] cw_col,
    input  logic [DW-1:0] cw_data
);
    logic [RW-1:0] rows [SIDE];

    assign rd_vec = rows[rd_row];

    for (genvar r = 0; r < SIDE; r++) begin : g_row
        // Storage for one row: clear, whole-row write-back, or one cell.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rows[r] <= '0;
            end else if (wb_en && wb_row == AW'(r)) begin
                rows[r] <= wb_vec;
            end else if (cw_en && cw_row == AW'(r)) begin
                for (int c = 0; c < SIDE; c++)
                    if (cw_col == AW'(c)) rows[r][c*DW +: DW] <= cw_data;
            end
        end
    end
endmodule

// File: rtl/dram_row_buffer.sv
// Row buffer: holds one open row, its index and an open flag, and accepts
// single-cell writes into the open row.
module dram_row_buffer #(
    parameter int SIDE = 4,
    parameter int DW   = 8,
    localparam int AW  = $clog2(SIDE),
    localparam int RW  = SIDE * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_row,
    input  logic [RW-1:0] load_vec,
    input  logic          cw_en,
    input  logic [AW-1:0] cw_col,
    input  logic [DW-1:0] cw_data,
    output logic [RW-1:0] buf_vec,
    output logic          is_open,
    output logic [AW-1:0] open_row
);
    // Open-row state: load replaces the whole row, a cell write patches one word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_vec  <= '0;
            is_open  <= 1'b0;
            open_row <= '0;
        end else if (load) begin
            buf_vec  <= load_vec;
            is_open  <= 1'b1;
            open_row <= load_row;
        end else if (cw_en) begin
            for (int c = 0; c < SIDE; c++)
                if (cw_col == AW'(c)) buf_vec[c*DW +: DW] <= cw_data;
        end
    end
endmodule

// File: rtl/dram_grid_model.sv
// Multiplexed-address DRAM model top. Qualifies strobes with refresh busy,
// gives row strobes priority over column strobes, and registers read data
// and the no-open-row error one cycle after acceptance.
module dram_grid_model
    import dram_grid_pkg::*;
#(
    parameter int SIDE           = 4,
    parameter int DW             = 8,
    parameter int REFRESH_PERIOD = 1024,
    parameter int REFRESH_CYCLES = 4,
    localparam int AW            = $clog2(SIDE),
    localparam int RW            = SIDE * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          row_stb,
    input  logic          col_stb,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic          col_err,
    output logic          busy
);
    dram_op_e      op;
    logic          bad_col;
    logic [RW-1:0] arr_vec;
    logic [RW-1:0] buf_vec;
    logic          row_open;
    logic [AW-1:0] open_row;
    logic [AW-1:0] ref_row;
    logic [DW-1:0] sel_word;

    // Decode the accepted operation for this cycle.
    always_comb begin
        op      = OP_IDLE;
        bad_col = 1'b0;
        if (!busy) begin
            if (row_stb)                  op = OP_OPEN;
            else if (col_stb && !row_open) bad_col = 1'b1;
            else if (col_stb)             op = wr_en ? OP_WRITE : OP_READ;
        end
    end

    // Select the addressed word of the open row.
    always_comb begin
        sel_word = '0;
        for (int c = 0; c < SIDE; c++)
            if (addr == AW'(c)) sel_word = buf_vec[c*DW +: DW];
    end

    dram_refresh_timer #(
        .REFRESH_PERIOD(REFRESH_PERIOD),
        .REFRESH_CYCLES(REFRESH_CYCLES),
        .SIDE(SIDE)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .busy(busy), .ref_row(ref_row)
    );

    dram_cell_array #(.SIDE(SIDE), .DW(DW)) u_array (
        .clk(clk), .rst_n(rst_n),
        .rd_row(addr), .rd_vec(arr_vec),
        .wb_en(op == OP_OPEN && row_open), .wb_row(open_row), .wb_vec(buf_vec),
        .cw_en(op == OP_WRITE), .cw_row(open_row), .cw_col(addr), .cw_data(wr_data)
    );

    dram_row_buffer #(.SIDE(SIDE), .DW(DW)) u_rowbuf (
        .clk(clk), .rst_n(rst_n),
        .load(op == OP_OPEN), .load_row(addr), .load_vec(arr_vec),
        .cw_en(op == OP_WRITE), .cw_col(addr), .cw_data(wr_data),
        .buf_vec(buf_vec), .is_open(row_open), .open_row(open_row)
    );

    // Registered read data, valid pulse and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
            col_err  <= 1'b0;
        end else begin
            rd_valid <= (op == OP_READ);
            col_err  <= bad_col;
            if (op == OP_READ) rd_data <= sel_word;
        end
    end
endmodule

// File: rtl/dram_grid_checks.sv
// Assertion checker bound to dram_grid_model; observes ports and the
// row-buffer and refresh state.
module dram_grid_checks #(
    parameter int AW             = 2,
    parameter int REFRESH_CYCLES = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          row_stb,
    input logic          col_stb,
    input logic [AW-1:0] addr,
    input logic          rd_valid,
    input logic          col_err,
    input logic          busy,
    input logic          row_open,
    input logic [AW-1:0] open_row,
    input logic [AW-1:0] ref_row
);
    int unsigned run_len;

    // Length of the current busy window.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= 0;
        else if (busy) run_len <= run_len + 1;
        else           run_len <= 0;
    end

    // R3 R6: a cycle never carries both a read result and an error.
    a_r3_valid_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && col_err));

    // R10: nothing is accepted while busy, so no response follows a busy cycle.
    a_r10_no_response_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!rd_valid && !col_err));

    // R6: a column strobe with no open row is answered by an error.
    a_r6_err_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (col_stb && !row_stb && !busy && !row_open) |=> col_err);

    // R2 R8: an accepted row strobe opens the addressed row.
    a_r2_row_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (row_stb && !busy) |=> (row_open && open_row == $past(addr)));

    // R9: every busy window lasts REFRESH_CYCLES cycles.
    a_r9_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == REFRESH_CYCLES));

    // R11: each refresh steps the row pointer by one, wrapping.
    a_r11_round_robin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (ref_row == AW'($past(ref_row) + 1'b1)));
endmodule

bind dram_grid_model dram_grid_checks #(.AW(AW), .REFRESH_CYCLES(REFRESH_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .row_stb(row_stb), .col_stb(col_stb), .addr(addr),
    .rd_valid(rd_valid), .col_err(col_err), .busy(busy),
    .row_open(row_open), .open_row(open_row), .ref_row(ref_row)
);

// File: tb/dram_grid_model_tb.sv
module dram_grid_model_tb;
    localparam int PERIOD = 40;
    localparam int RCYC   = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       row_stb, col_stb, wr_en;
    logic [1:0] addr;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       rd_valid, col_err, busy;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    int stalls = 0;

    // Reference model state
    int  m_arr [4][4];
    int  m_buf [4];
    bit  m_open;
    int  m_orow;
    bit  m_busy;
    int  m_cnt, m_left;
    bit  e_valid, e_err;
    int  e_data;

    always #4 clk = ~clk;

    dram_grid_model #(
        .SIDE(4), .DW(8), .REFRESH_PERIOD(PERIOD), .REFRESH_CYCLES(RCYC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .row_stb(row_stb), .col_stb(col_stb),
        .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .rd_valid(rd_valid), .col_err(col_err), .busy(busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Advance the model by one clock edge using the inputs being driven.
    task automatic model_step();
        bit acc;
        if (!rst_n) begin
            for (int r = 0; r < 4; r++) for (int c = 0; c < 4; c++) m_arr[r][c] = 0;
            for (int c = 0; c < 4; c++) m_buf[c] = 0;
            m_open = 0; m_orow = 0; m_busy = 0; m_cnt = 0; m_left = 0;
            e_valid = 0; e_err = 0; e_data = 0;
            return;
        end
        acc = !m_busy;
        e_valid = 0; e_err = 0;
        if (acc && row_stb) begin
            if (m_open) for (int c = 0; c < 4; c++) m_arr[m_orow][c] = m_buf[c];
            for (int c = 0; c < 4; c++) m_buf[c] = m_arr[addr][c];
            m_open = 1; m_orow = addr;
        end else if (acc && col_stb) begin
            if (!m_open) e_err = 1;
            else if (wr_en) begin
                m_buf[addr] = wr_data; m_arr[m_orow][addr] = wr_data;
            end else begin
                e_valid = 1; e_data = m_buf[addr];
            end
        end
        if (m_busy) begin
            if (m_left == 0) m_busy = 0; else m_left--;
        end
        if (m_cnt == PERIOD - 1) begin
            m_cnt = 0; m_busy = 1; m_left = RCYC - 1;
        end else m_cnt++;
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        cycles++;
        chk("R9 busy", busy, m_busy);
        chk("R3 rd_valid", rd_valid, e_valid);
        chk("R6 col_err", col_err, e_err);
        if (e_valid) chk("R3 rd_data", rd_data, e_data);
    endtask

    // Present a request and hold it until accepted (R10).
    task automatic issue(input bit rs, input bit cs, input bit we,
                         input int a, input int d);
        bit done = 0;
        row_stb = rs; col_stb = cs; wr_en = we; addr = 2'(a); wr_data = 8'(d);
        while (!done) begin
            done = !m_busy;
            if (!done) stalls++;
            tick();
        end
        row_stb = 0; col_stb = 0; wr_en = 0;
    endtask

    function automatic int pat(input int r, input int c);
        return 8'hA0 + r * 16 + c;
    endfunction

    initial begin
        rst_n = 0; row_stb = 0; col_stb = 0; wr_en = 0; addr = 0; wr_data = 0;
        repeat (3) tick();
        rst_n = 1;
        // R1: outputs idle after reset
        chk("R1 busy", busy, 0);
        chk("R1 rd_valid", rd_valid, 0);
        chk("R1 col_err", col_err, 0);
        // R6 R1: column access before any row is open
        issue(0, 1, 0, 1, 0);
        chk("R6 err no open row", col_err, 1);
        chk("R6 no data", rd_valid, 0);
        issue(0, 1, 1, 2, 8'h55);
        chk("R6 write with no row", col_err, 1);
        // R1: every cell reads zero
        for (int r = 0; r < 4; r++) begin
            issue(1, 0, 0, r, 0);
            for (int c = 0; c < 4; c++) begin
                issue(0, 1, 0, c, 0);
                chk("R1 cell zero", rd_data, 0);
            end
        end
        // R5 R7: fill each row through its buffer
        for (int r = 0; r < 4; r++) begin
            issue(1, 0, 0, r, 0);
            for (int c = 0; c < 4; c++) begin
                issue(0, 1, 1, c, pat(r, c));
                chk("R5 write gives no rd_valid", rd_valid, 0);
            end
        end
        // R2 R3 R4: row 2 then several columns, one row strobe
        issue(1, 0, 0, 2, 0);
        issue(0, 1, 0, 1, 0);
        chk("R3 supercell (2,1)", rd_data, pat(2, 1));
        issue(0, 1, 0, 3, 0);
        chk("R4 second column same row", rd_data, pat(2, 3));
        issue(0, 1, 0, 0, 0);
        chk("R4 third column same row", rd_data, pat(2, 0));
        // R5: overwrite then read in open row
        issue(0, 1, 1, 3, 8'h3C);
        issue(0, 1, 0, 3, 0);
        chk("R5 read after write", rd_data, 8'h3C);
        // R7: switch rows and back
        issue(1, 0, 0, 0, 0);
        issue(0, 1, 0, 2, 0);
        chk("R7 other row intact", rd_data, pat(0, 2));
        issue(1, 0, 0, 2, 0);
        issue(0, 1, 0, 3, 0);
        chk("R7 written value survived", rd_data, 8'h3C);
        // R8: both strobes, row wins; column write must not land
        issue(1, 1, 1, 1, 8'hFF);
        chk("R8 no read pulse", rd_valid, 0);
        issue(0, 1, 0, 1, 0);
        chk("R8 row 1 opened, cell untouched", rd_data, pat(1, 1));
        // Random traffic across many refresh windows (R9 R10 R11)
        for (int i = 0; i < 600; i++) begin
            int k = $urandom_range(0, 9);
            if (k == 0)      issue(1, 1, $urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 255));
            else if (k < 3)  issue(1, 0, 0, $urandom_range(0, 3), 0);
            else if (k < 6)  issue(0, 1, 1, $urandom_range(0, 3), $urandom_range(0, 255));
            else if (k < 9)  issue(0, 1, 0, $urandom_range(0, 3), 0);
            else             tick();
        end
        chk("R10 some requests were stalled", int'(stalls > 0), 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule